// File: doc/BRIEF.md
# Processor Status, Stack and Software-Break Sequencer

This block holds the eight-bit flag register of a small 8-bit processor core. It carries out the operations that move that register to and from the stack, and it runs the multi-cycle software-break entry. The stack is a one-byte pointer into page one of memory. The sequencer also computes the target of an indirect jump, including the wrap of the pointer's high-byte fetch inside its own page. The block has one byte-wide synchronous memory port. Each access takes exactly one clock. A read returns its data in the same cycle the address is presented, and that data is captured at the closing edge.

A command is offered on `cmd_valid` with an opcode on `cmd_op`. Operands travel on `cmd_data`, `cmd_pc` or `cmd_ptr`. A command is taken only in state IDLE.

The state machine has these states:
- IDLE: waits for a command.
- PUSH_P: writes the flags to the stack.
- PULL_P: reads the flags from the stack.
- BRK_PCH, BRK_PCL, BRK_P: the three break pushes.
- VEC_LO, VEC_HI: the vector fetch.
- JI_LO, JI_HI: the pointer fetch for the indirect jump.
- FIN: one cycle with `done` high.

The transitions are as follows. IDLE goes to FIN for a load, to PUSH_P for a push and to PULL_P for a pull. For a break it goes to BRK_PCH, and for an indirect jump to JI_LO. The break runs BRK_PCH, BRK_PCL, BRK_P, VEC_LO, VEC_HI and then FIN. The indirect jump runs JI_LO, JI_HI and then FIN. PUSH_P and PULL_P go to FIN. FIN always returns to IDLE. Undefined opcodes keep the machine in IDLE.

Top module: `psr_stack_seq`

## Requirements
- R1: After reset, `status` is 0x24 (interrupt mask at bit 2 and reserved bit 5 set), `sp` is 0xFD, and `busy`, `done` and `mem_req` are all low.
- R2: Opcode 1 (load) sets `status` to (`cmd_data` AND 0xDF) OR 0x20. Bit 5 therefore always reads as one. `done` pulses in the cycle after acceptance and no memory access is made.
- R3: Opcode 2 (push flags) makes one write of `status` OR 0x10 (break bit 4) to address 0x0100+`sp`, then decrements `sp`. The held `status` is unchanged.
- R4: Opcode 3 (pull flags) increments `sp`, reads address 0x0100 plus the new `sp`, and loads `status` from that byte with the rule of R2.
- R5: Opcode 4 (break) makes three stack writes, in order, at the current and successively lower stack addresses. It writes the high byte of `cmd_pc`+1, then its low byte, then `status` OR 0x10. `sp` ends three lower.
- R6: After its pushes, the break sets `status` bit 2. It then reads 0xFFFE and then 0xFFFF, and `result` becomes the little-endian word read. No other flag bit changes.
- R7: Opcode 5 (indirect jump) with a pointer whose low byte is not 0xFF reads the pointer and then pointer+1. `result` is {second byte, first byte}.
- R8: An indirect jump whose pointer low byte is 0xFF reads the high byte from the pointer minus 0xFF, the start of the same page, and never from the next page.
- R9: There is at most one memory access per cycle, and every write is on the stack page. `done` is a one-cycle pulse. Commands offered while `busy` is high are ignored. Opcodes 0, 6 and 7 cause no access, no `done` and no state change.
- R10: `sp` wraps within eight bits. A push at `sp`=0x00 writes 0x0100 and leaves `sp`=0xFF. A pull at 0xFF reads 0x0100 and leaves `sp`=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 3 | Opcode: 1 load, 2 push, 3 pull, 4 break, 5 indirect jump |
| cmd_data | input | 8 | Byte for the load opcode |
| cmd_pc | input | 16 | Program counter of the break instruction |
| cmd_ptr | input | 16 | Pointer for the indirect jump |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | New program counter from a break or an indirect jump |
| status | output | 8 | Held flag register |
| sp | output | 8 | Stack pointer |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data for the current access |

## Verification
The bench goes after the pointer at 0x03FF. A design that carries into the high byte would fetch 0x0400 and return a target in the wrong page. It also checks that pushed flags carry bit 4 while the held register does not gain it. A design that stored the break bit would show it on `status` after a push. A pull of 0xF3 and loads of 0x00 and 0x5A probe the bit-5 rule, which a design that dropped the mask or the force would fail. The stack pointer is driven down to 0x00 and past it to catch arithmetic that is not kept to eight bits. A load offered in the middle of a break must leave `status` untouched, because a design that takes commands while busy would corrupt the flags.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int DW = 8;
    localparam int AW = 16;

    localparam int FLG_I = 2;
    localparam int FLG_B = 4;
    localparam int FLG_R = 5;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_LOAD = 3'd1,
        OP_PUSH = 3'd2,
        OP_PULL = 3'd3,
        OP_BRK  = 3'd4,
        OP_JIND = 3'd5
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_P,
        ST_PULL_P,
        ST_BRK_PCH,
        ST_BRK_PCL,
        ST_BRK_P,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_JI_LO,
        ST_JI_HI,
        ST_FIN
    } state_e;
endpackage

// File: rtl/psr_status_reg.sv
module psr_status_reg
    import psr_pkg::*;
#(
    parameter logic [DW-1:0] INIT = 8'h24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [DW-1:0] load_val,
    input  logic          set_imask,
    output logic [DW-1:0] flags
);
    localparam logic [DW-1:0] RSV_MASK = DW'(1) << FLG_R;
    localparam logic [DW-1:0] I_MASK   = DW'(1) << FLG_I;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= INIT;
        end else if (load_en) begin
            flags <= (load_val & ~RSV_MASK) | RSV_MASK;
        end else if (set_imask) begin
            flags <= flags | I_MASK;
        end
    end

    AST_RSV_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        flags[FLG_R]); // R2

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !set_imask) |=> $stable(flags)); // R3
endmodule

// File: rtl/psr_stack_ptr.sv
module psr_stack_ptr
    import psr_pkg::*;
#(
    parameter logic [DW-1:0] INIT = 8'hFD,
    parameter logic [DW-1:0] PAGE = 8'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pull,
    output logic [DW-1:0] sp,
    output logic [AW-1:0] push_addr,
    output logic [AW-1:0] pull_addr
);
    logic [DW-1:0] sp_up;

    assign sp_up     = sp + DW'(1);
    assign push_addr = {PAGE, sp};
    assign pull_addr = {PAGE, sp_up};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= INIT;
        end else if (push) begin
            sp <= sp - DW'(1);
        end else if (pull) begin
            sp <= sp_up;
        end
    end

    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (sp == $past(sp) - DW'(1))); // R3

    AST_PULL_INC: assert property (@(posedge clk) disable iff (!rst_n)
        pull |=> (sp == $past(sp) + DW'(1))); // R4

    AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pull)); // R9
endmodule

// File: rtl/psr_ptr_next.sv
module psr_ptr_next
    import psr_pkg::*;
(
    input  logic [AW-1:0] ptr,
    output logic [AW-1:0] hi_addr
);
    localparam int LOW_W = AW / 2;

    logic [LOW_W-1:0] low_next;

    // Only the low half advances; the page half is never carried into.
    assign low_next = ptr[LOW_W-1:0] + LOW_W'(1);
    assign hi_addr  = {ptr[AW-1:LOW_W], low_next};
endmodule

// File: rtl/psr_stack_seq.sv
module psr_stack_seq
    import psr_pkg::*;
#(
    parameter logic [DW-1:0] PSR_INIT   = 8'h24,
    parameter logic [DW-1:0] SP_INIT    = 8'hFD,
    parameter logic [DW-1:0] STACK_PAGE = 8'h01,
    parameter logic [AW-1:0] VEC_ADDR   = 16'hFFFE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [DW-1:0] cmd_data,
    input  logic [AW-1:0] cmd_pc,
    input  logic [AW-1:0] cmd_ptr,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] result,
    output logic [DW-1:0] status,
    output logic [DW-1:0] sp,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    localparam logic [DW-1:0] B_MASK   = DW'(1) << FLG_B;
    localparam logic [AW-1:0] VEC_HIGH = VEC_ADDR + AW'(1);

    state_e        state, state_nx;
    logic [AW-1:0] ret_pc;
    logic [AW-1:0] ptr_q;
    logic [DW-1:0] lo_byte;
    logic          st_load, st_imask, sp_push, sp_pull;
    logic [DW-1:0] st_val;
    logic [AW-1:0] push_addr, pull_addr, ptr_hi_addr;
    logic          accept;

    psr_status_reg #(.INIT(PSR_INIT)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (st_load),
        .load_val  (st_val),
        .set_imask (st_imask),
        .flags     (status)
    );

    psr_stack_ptr #(.INIT(SP_INIT), .PAGE(STACK_PAGE)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (sp_push),
        .pull      (sp_pull),
        .sp        (sp),
        .push_addr (push_addr),
        .pull_addr (pull_addr)
    );

    psr_ptr_next u_ptr (
        .ptr     (ptr_q),
        .hi_addr (ptr_hi_addr)
    );

    assign accept = (state == ST_IDLE) && cmd_valid;
    assign busy   = (state != ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (cmd_op)
                        OP_LOAD: state_nx = ST_FIN;
                        OP_PUSH: state_nx = ST_PUSH_P;
                        OP_PULL: state_nx = ST_PULL_P;
                        OP_BRK:  state_nx = ST_BRK_PCH;
                        OP_JIND: state_nx = ST_JI_LO;
                        default: state_nx = ST_IDLE;
                    endcase
                end
            end
            ST_PUSH_P:  state_nx = ST_FIN;
            ST_PULL_P:  state_nx = ST_FIN;
            ST_BRK_PCH: state_nx = ST_BRK_PCL;
            ST_BRK_PCL: state_nx = ST_BRK_P;
            ST_BRK_P:   state_nx = ST_VEC_LO;
            ST_VEC_LO:  state_nx = ST_VEC_HI;
            ST_VEC_HI:  state_nx = ST_FIN;
            ST_JI_LO:   state_nx = ST_JI_HI;
            ST_JI_HI:   state_nx = ST_FIN;
            ST_FIN:     state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs and register controls
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        done      = 1'b0;
        st_load   = 1'b0;
        st_val    = cmd_data;
        st_imask  = 1'b0;
        sp_push   = 1'b0;
        sp_pull   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept && (cmd_op == OP_LOAD)) st_load = 1'b1;
            end
            ST_PUSH_P: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_addr = push_addr;
                mem_wdata = status | B_MASK; sp_push = 1'b1;
            end
            ST_PULL_P: begin
                mem_req = 1'b1; mem_addr = pull_addr; sp_pull = 1'b1;
                st_load = 1'b1; st_val = mem_rdata;
            end
            ST_BRK_PCH: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_addr = push_addr;
                mem_wdata = ret_pc[AW-1:DW]; sp_push = 1'b1;
            end
            ST_BRK_PCL: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_addr = push_addr;
                mem_wdata = ret_pc[DW-1:0]; sp_push = 1'b1;
            end
            ST_BRK_P: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_addr = push_addr;
                mem_wdata = status | B_MASK; sp_push = 1'b1;
                st_imask = 1'b1;
            end
            ST_VEC_LO: begin mem_req = 1'b1; mem_addr = VEC_ADDR; end
            ST_VEC_HI: begin mem_req = 1'b1; mem_addr = VEC_HIGH; end
            ST_JI_LO:  begin mem_req = 1'b1; mem_addr = ptr_q; end
            ST_JI_HI:  begin mem_req = 1'b1; mem_addr = ptr_hi_addr; end
            ST_FIN:    done = 1'b1;
            default:   ;
        endcase
    end

    // operand and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_pc  <= '0;
            ptr_q   <= '0;
            lo_byte <= '0;
            result  <= '0;
        end else begin
            if (accept) begin
                ret_pc <= cmd_pc + AW'(1);
                ptr_q  <= cmd_ptr;
            end
            if (state == ST_VEC_LO || state == ST_JI_LO) lo_byte <= mem_rdata;
            if (state == ST_VEC_HI || state == ST_JI_HI) result <= {mem_rdata, lo_byte};
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_WR_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_req && mem_addr[AW-1:DW] == STACK_PAGE)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !done)); // R9

    AST_VEC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VEC_LO) |-> status[FLG_I]); // R6

    AST_JI_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_JI_HI) |-> (mem_addr[AW-1:DW] == ptr_q[AW-1:DW])); // R8
endmodule

// File: tb/tb_psr_stack_seq.sv
module tb_psr_stack_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [7:0]  cmd_data = 8'h00;
    logic [15:0] cmd_pc = 16'h0000;
    logic [15:0] cmd_ptr = 16'h0000;
    logic        busy, done, mem_req, mem_we;
    logic [15:0] result, mem_addr;
    logic [7:0]  status, sp, mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    psr_stack_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_pc(cmd_pc), .cmd_ptr(cmd_ptr),
        .busy(busy), .done(done), .result(result), .status(status), .sp(sp),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // bench memory: stack page stored, everything else computed
    logic [7:0] page1 [256];
    function automatic logic [7:0] rom_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction
    assign mem_rdata = (mem_addr[15:8] == 8'h01) ? page1[mem_addr[7:0]] : rom_byte(mem_addr);
    always @(posedge clk) if (mem_req && mem_we && mem_addr[15:8] == 8'h01) page1[mem_addr[7:0]] <= mem_wdata;

    // reference model state
    int st_m = 'h24;
    int sp_m = 'hFD;
    int stk_m [256];
    int q_we[$];
    int q_addr[$];
    int q_data[$];
    int res_m;

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic int ld(input int v);
        return (v & 'hDF) | 'h20;
    endfunction

    task automatic exp_push(input int v);
        q_we.push_back(1); q_addr.push_back('h100 + sp_m); q_data.push_back(v);
        stk_m[sp_m] = v;
        sp_m = (sp_m - 1) & 'hFF;
    endtask

    task automatic exp_read(input int a);
        q_we.push_back(0); q_addr.push_back(a); q_data.push_back(0);
    endtask

    task automatic run(input int op, input int data, input int pc, input int ptr,
                       input bit inject, input string rq);
        int lo, hi, p2;
        q_we.delete(); q_addr.delete(); q_data.delete();
        case (op)
            1: st_m = ld(data);
            2: exp_push(st_m | 'h10);
            3: begin
                sp_m = (sp_m + 1) & 'hFF;
                exp_read('h100 + sp_m);
                st_m = ld(stk_m[sp_m]);
            end
            4: begin
                exp_push(((pc + 1) >> 8) & 'hFF);
                exp_push((pc + 1) & 'hFF);
                exp_push(st_m | 'h10);
                st_m = st_m | 'h04;
                exp_read('hFFFE); exp_read('hFFFF);
                res_m = {rom_byte(16'hFFFF), rom_byte(16'hFFFE)};
            end
            5: begin
                p2 = (ptr & 'hFF00) | ((ptr + 1) & 'hFF);
                exp_read(ptr); exp_read(p2);
                lo = rom_byte(16'(ptr)); hi = rom_byte(16'(p2));
                res_m = (hi << 8) | lo;
            end
            default: ;
        endcase
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_data = 8'(data);
        cmd_pc = 16'(pc); cmd_ptr = 16'(ptr);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (op < 1 || op > 5) begin
            chk({rq, " no access"}, mem_req, 0);
            chk({rq, " no done"}, done, 0);
            chk({rq, " not busy"}, busy, 0);
            chk({rq, " status kept"}, status, st_m);
            chk({rq, " sp kept"}, sp, sp_m);
            return;
        end
        for (int i = 0; i < q_we.size(); i++) begin
            if (inject && i == 0) begin
                cmd_valid = 1'b1; cmd_op = 3'd1; cmd_data = 8'h00;
            end else begin
                cmd_valid = 1'b0;
            end
            chk({rq, " req"}, mem_req, 1);
            chk({rq, " we"}, mem_we, q_we[i]);
            chk({rq, " addr"}, mem_addr, q_addr[i]);
            if (q_we[i] == 1) chk({rq, " wdata"}, mem_wdata, q_data[i]);
            chk({rq, " early done"}, done, 0);
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk({rq, " done"}, done, 1);
        chk({rq, " done no access"}, mem_req, 0);
        chk({rq, " status"}, status, st_m);
        chk({rq, " sp"}, sp, sp_m);
        if (op == 4 || op == 5) chk({rq, " result"}, result, res_m);
        @(negedge clk);
        chk("R9 done one cycle", done, 0);
        chk("R9 idle after", busy, 0);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) stk_m[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status", status, 'h24);
        chk("R1 sp", sp, 'hFD);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 mem_req", mem_req, 0);

        run(1, 'hFF, 0, 0, 0, "R2 load FF");
        run(1, 'h00, 0, 0, 0, "R2 load 00");
        run(1, 'h5A, 0, 0, 0, "R2 load 5A");
        run(1, 'hC3, 0, 0, 0, "R2 load C3");
        run(2, 0, 0, 0, 0, "R3 push");
        run(1, 'h00, 0, 0, 0, "R2 load before pull");
        run(3, 0, 0, 0, 0, "R4 pull");
        run(1, 'h01, 0, 0, 0, "R2 load before brk");
        run(4, 0, 'h12FF, 0, 1, "R5 R6 R9 brk with busy command");
        run(5, 0, 0, 'h0280, 0, "R7 jind normal");
        run(5, 0, 0, 'h03FF, 0, "R8 jind page wrap");
        run(5, 0, 0, 'h00FE, 0, "R7 jind FE");
        run(0, 'h11, 0, 0, 0, "R9 opcode 0");
        run(6, 'h11, 0, 0, 0, "R9 opcode 6");
        run(7, 'h11, 0, 0, 0, "R9 opcode 7");
        while (sp_m != 0) run(2, 0, 0, 0, 0, "R3 push run");
        run(2, 0, 0, 0, 0, "R10 push at 00");
        run(1, 'h00, 0, 0, 0, "R2 load before wrap pull");
        run(3, 0, 0, 0, 0, "R10 pull at FF");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule